// File: doc/BRIEF.md
# CAN Receive Message Queue

This block is a small receive queue that sits behind the identifier filter of a CAN controller. The filter offers each accepted frame as four 32-bit words (identifier, property word carrying length and filter index, low data word, high data word) together with a one-cycle valid strobe. The queue keeps up to three such frames. It always presents the oldest pending frame on its head outputs.

Software reads the fill level first. It then reads the four head words and frees the entry with a one-cycle release pulse. The queue reports a fill level, a full flag and a sticky overrun flag, and drives three interrupt lines derived from them.

A configuration input decides what a frame that arrives while the queue is full does. With the lock setting high, the newcomer is discarded. With it low, the newcomer takes the place of the most recently stored frame. In both cases the older frames stay in place and keep their order.

Top module: `canrx_queue`

## Requirements
- R1: After reset the level is 0 and the full, overrun and all three interrupt outputs are low.
- R2: A strobed frame arriving while fewer than three frames are held is stored, and `level` (2-bit binary count, 0 = empty, 3 = full) rises by one.
- R3: While `level` is non-zero, the head outputs show the four words of the oldest stored frame, and frames leave in arrival order.
- R4: A release pulse while `level` is non-zero removes the head frame, exposes the next one and lowers `level` by one.
- R5: A release pulse while `level` is 0 is ignored: `level` stays 0 and no underflow occurs.
- R6: `full` is high exactly when `level` is 3.
- R7: A frame strobed while three frames are held and no release is applied sets `overrun`. `overrun` stays high until a cycle in which `ovr_clr` is high and no new overflow occurs; a new overflow in the same cycle as a clear leaves it set.
- R8: On overflow with `lock_on_full` = 1, the incoming frame is discarded and the three stored frames are unchanged.
- R9: On overflow with `lock_on_full` = 0, the incoming frame replaces the most recently stored frame, the two older frames are unchanged, and `level` stays 3.
- R10: A release and a new frame in the same cycle while full are both applied: the head is removed, the new frame becomes the newest, `level` stays 3 and no overrun is flagged.
- R11: `irq_pending` is high whenever `level` is non-zero, `irq_full` equals `full`, and `irq_overrun` equals `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_on_full | input | 1 | 1: drop frames that arrive while full; 0: overwrite newest stored frame |
| frm_valid | input | 1 | One-cycle strobe for an incoming frame |
| frm_id | input | 32 | Incoming identifier word |
| frm_prop | input | 32 | Incoming property word (length, filter index) |
| frm_dlo | input | 32 | Incoming low data word |
| frm_dhi | input | 32 | Incoming high data word |
| rel_pulse | input | 1 | Release of the head frame |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| head_id | output | 32 | Identifier word of the oldest frame |
| head_prop | output | 32 | Property word of the oldest frame |
| head_dlo | output | 32 | Low data word of the oldest frame |
| head_dhi | output | 32 | High data word of the oldest frame |
| level | output | 2 | Number of frames held |
| full | output | 1 | Three frames held |
| overrun | output | 1 | Sticky overflow flag |
| irq_pending | output | 1 | Interrupt: at least one frame pending |
| irq_full | output | 1 | Interrupt: queue full |
| irq_overrun | output | 1 | Interrupt: overrun occurred |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. A stored frame, a release, an overflow and a flag clear all take effect in the registers at the edge that samples them, and the head, level, flag and interrupt outputs show the new state right after that edge. The bench drives inputs on the falling edge, holds them through one rising edge, and compares all outputs at the next falling edge against a model that it updates with the same inputs. It also tags each comparison with the requirement for the event of that cycle: overflow under either policy, release with arrival while full, or release while empty.

// File: rtl/canrxq_pkg.sv
package canrxq_pkg;
    localparam int QDEPTH = 3;
    localparam int SLOT_W = 2;

    typedef struct packed {
        logic [SLOT_W-1:0] rd_ptr;
        logic [SLOT_W-1:0] count;
        logic              ovr;
    } rxq_state_t;
endpackage

// File: rtl/canrxq_ctrl.sv
module canrxq_ctrl
    import canrxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              ovr_clr,
    input  logic              lock_on_full,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] rd_slot,
    output logic [SLOT_W-1:0] count,
    output logic              full,
    output logic              ovr
);
    rxq_state_t s_d, s_q;

    logic pop_ok, full_now, overflow, accept;

    function automatic logic [SLOT_W-1:0] wrap(input logic [SLOT_W:0] sum);
        logic [SLOT_W:0] r;
        r = (sum >= (SLOT_W+1)'(QDEPTH)) ? sum - (SLOT_W+1)'(QDEPTH) : sum;
        return r[SLOT_W-1:0];
    endfunction

    always_comb begin
        s_d      = s_q;
        wr_en    = 1'b0;
        wr_slot  = '0;
        full_now = (s_q.count == SLOT_W'(QDEPTH));
        pop_ok   = pop && (s_q.count != '0);
        overflow = push && full_now && !pop_ok;
        accept   = push && !overflow;

        if (accept) begin
            wr_en   = 1'b1;
            wr_slot = wrap({1'b0, s_q.rd_ptr} + {1'b0, s_q.count});
        end else if (overflow && !lock_on_full) begin
            wr_en   = 1'b1;
            wr_slot = wrap({1'b0, s_q.rd_ptr} + (SLOT_W+1)'(QDEPTH - 1));
        end

        if (pop_ok) begin
            s_d.rd_ptr = wrap({1'b0, s_q.rd_ptr} + (SLOT_W+1)'(1));
        end

        case ({accept, pop_ok})
            2'b10:   s_d.count = s_q.count + SLOT_W'(1);
            2'b01:   s_d.count = s_q.count - SLOT_W'(1);
            default: s_d.count = s_q.count;
        endcase

        s_d.ovr = overflow || (s_q.ovr && !ovr_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_slot = s_q.rd_ptr;
    assign count   = s_q.count;
    assign full    = full_now;
    assign ovr     = s_q.ovr;

    // R2
    grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && s_q.count < SLOT_W'(QDEPTH)) |=> (s_q.count == $past(s_q.count) + SLOT_W'(1)));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && s_q.count == '0) |=> (s_q.count == '0));

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && s_q.count == SLOT_W'(QDEPTH)) |=> s_q.ovr);

    // R7
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovr && !ovr_clr) |=> s_q.ovr);

    // R10
    swap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && s_q.count == SLOT_W'(QDEPTH) && !ovr_clr)
            |=> (s_q.count == SLOT_W'(QDEPTH) && s_q.ovr == $past(s_q.ovr)));
endmodule

// File: rtl/canrxq_store.sv
module canrxq_store
    import canrxq_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int FRM_W = 4 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [FRM_W-1:0]  wr_frame,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [FRM_W-1:0]  head_frame
);
    logic [FRM_W-1:0] slot_d [QDEPTH];
    logic [FRM_W-1:0] slot_q [QDEPTH];

    for (genvar g = 0; g < QDEPTH; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && wr_slot == SLOT_W'(g)) slot_d[g] = wr_frame;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d[g];
        end
    end

    always_comb begin
        head_frame = slot_q[0];
        for (int k = 1; k < QDEPTH; k++) begin
            if (rd_slot == SLOT_W'(k)) head_frame = slot_q[k];
        end
    end

    // R8
    slot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (slot_q[0] == $past(slot_q[0]) && slot_q[1] == $past(slot_q[1])
                    && slot_q[2] == $past(slot_q[2])));
endmodule

// File: rtl/canrx_queue.sv
module canrx_queue
    import canrxq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_on_full,
    input  logic              frm_valid,
    input  logic [WORD_W-1:0] frm_id,
    input  logic [WORD_W-1:0] frm_prop,
    input  logic [WORD_W-1:0] frm_dlo,
    input  logic [WORD_W-1:0] frm_dhi,
    input  logic              rel_pulse,
    input  logic              ovr_clr,
    output logic [WORD_W-1:0] head_id,
    output logic [WORD_W-1:0] head_prop,
    output logic [WORD_W-1:0] head_dlo,
    output logic [WORD_W-1:0] head_dhi,
    output logic [1:0]        level,
    output logic              full,
    output logic              overrun,
    output logic              irq_pending,
    output logic              irq_full,
    output logic              irq_overrun
);
    localparam int FRM_W = 4 * WORD_W;

    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot, rd_slot, cnt;
    logic [FRM_W-1:0]  head_frame;

    canrxq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (frm_valid),
        .pop          (rel_pulse),
        .ovr_clr      (ovr_clr),
        .lock_on_full (lock_on_full),
        .wr_en        (wr_en),
        .wr_slot      (wr_slot),
        .rd_slot      (rd_slot),
        .count        (cnt),
        .full         (full),
        .ovr          (overrun)
    );

    canrxq_store #(.WORD_W(WORD_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_frame   ({frm_id, frm_prop, frm_dlo, frm_dhi}),
        .rd_slot    (rd_slot),
        .head_frame (head_frame)
    );

    assign {head_id, head_prop, head_dlo, head_dhi} = head_frame;
    assign level       = cnt;
    assign irq_pending = (cnt != '0);
    assign irq_full    = full;
    assign irq_overrun = overrun;

    // R11
    pend_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !rel_pulse) |=> irq_pending);
endmodule

// File: tb/canrx_queue_test.sv
module canrx_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_on_full = 1'b0, frm_valid = 1'b0, rel_pulse = 1'b0, ovr_clr = 1'b0;
    logic [31:0] frm_id = '0, frm_prop = '0, frm_dlo = '0, frm_dhi = '0;
    logic [31:0] head_id, head_prop, head_dlo, head_dhi;
    logic [1:0]  level;
    logic        full, overrun, irq_pending, irq_full, irq_overrun;

    int n_chk = 0, n_fail = 0;
    logic [127:0] m_q [3];
    int           m_cnt = 0;
    logic         m_ovr = 1'b0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    canrx_queue uut (
        .clk(clk), .rst_n(rst_n), .lock_on_full(lock_on_full), .frm_valid(frm_valid),
        .frm_id(frm_id), .frm_prop(frm_prop), .frm_dlo(frm_dlo), .frm_dhi(frm_dhi),
        .rel_pulse(rel_pulse), .ovr_clr(ovr_clr), .head_id(head_id), .head_prop(head_prop),
        .head_dlo(head_dlo), .head_dhi(head_dhi), .level(level), .full(full),
        .overrun(overrun), .irq_pending(irq_pending), .irq_full(irq_full),
        .irq_overrun(irq_overrun)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare(input string ev);
        chk({ev, "/R2 level"}, 128'(level), 128'(m_cnt));
        chk("R6 full", 128'(full), 128'(m_cnt == 3));
        chk({ev, "/R7 overrun"}, 128'(overrun), 128'(m_ovr));
        chk("R11 irq_pending", 128'(irq_pending), 128'(m_cnt != 0));
        chk("R11 irq_full", 128'(irq_full), 128'(m_cnt == 3));
        chk("R11 irq_overrun", 128'(irq_overrun), 128'(m_ovr));
        if (m_cnt != 0)
            chk({ev, "/R3 head"}, {head_id, head_prop, head_dlo, head_dhi}, m_q[0]);
    endtask

    task automatic step(input logic v, input logic r, input logic c, input logic lk,
                        input logic [127:0] f);
        string ev;
        bit    ovf;
        ev = "R4";
        frm_valid = v; rel_pulse = r; ovr_clr = c; lock_on_full = lk;
        {frm_id, frm_prop, frm_dlo, frm_dhi} = f;
        ovf = 1'b0;
        if (r && m_cnt == 0) ev = "R5";
        if (v && r && m_cnt == 3) ev = "R10";
        if (r && m_cnt > 0) begin
            m_q[0] = m_q[1]; m_q[1] = m_q[2];
            m_cnt--;
        end
        if (v) begin
            if (m_cnt < 3) begin
                m_q[m_cnt] = f;
                m_cnt++;
            end else begin
                ovf = 1'b1;
                ev = lk ? "R8" : "R9";
                if (!lk) m_q[2] = f;
            end
        end
        m_ovr = ovf | (m_ovr & ~c);
        @(negedge clk);
        compare(ev);
        if (m_cnt == 3) begin
            // R8 and R9: older entries are checked by draining order later; newest visible only at head
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 level", 128'(level), 128'(0));
        chk("R1 flags", 128'({full, overrun, irq_pending, irq_full, irq_overrun}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 level after release", 128'(level), 128'(0));

        // R5 release on empty queue
        step(1'b0, 1'b1, 1'b0, 1'b1, '0);

        // R8 directed: fill, overflow with lock, drain and confirm order
        for (int k = 0; k < 4; k++)
            step(1'b1, 1'b0, 1'b0, 1'b1, {4{32'hA000_0000 + 32'(k)}});
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0, 1'b1, '0);

        // R9 directed: fill, overwrite newest, drain
        for (int k = 0; k < 4; k++)
            step(1'b1, 1'b0, 1'b0, 1'b0, {4{32'hB000_0000 + 32'(k)}});
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b0, 1'b0, '0);

        // sweep of input combinations across all fill levels and both policies
        for (int i = 0; i < 512; i++) begin
            logic v, r, c, lk;
            logic [127:0] f;
            if ((i / 16) % 2 == 0) begin
                v = (i % 4 != 3);
                r = (i % 5 == 0);
            end else begin
                v = (i % 3 == 0);
                r = 1'b1;
            end
            c  = (i % 13 == 0);
            lk = ((i / 64) % 2 == 1);
            f  = {32'h1000_0000 + 32'(i), 32'h0008_0000 | 32'(i % 28),
                  32'(i) * 32'h9E37_79B9, ~32'(i)};
            step(v, r, c, lk, f);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule